// File: doc/BRIEF.md
# Bi-phase Interval Bit Decoder

The block recovers a bit stream from a demodulated bi-phase data line. It works only from edge spacing. A synchronizer and edge detector turn the line into edge events. An interval counter measures the cycles between consecutive edges. A two-state machine keeps at most one earlier interval, which it uses to pair two half-period intervals into a single one bit.

The nominal bit period `P` is `CLK_HZ / BIT_HZ` clock cycles, where `BIT_HZ` defaults to 2000. A full-period interval is decoded as a zero. Two half-period intervals are decoded as a one. A half-period interval that follows an over-long gap is also decoded as a one when the line settles low after the edge. When a gap is too long to produce any bit, the block raises an abort strobe so that downstream byte framing can return to idle.

The machine has two states:

- `ST_EMPTY` holds no interval.
- `ST_HELD` holds one earlier interval.

It has three named transitions, each taken on an edge:

- *stash* (`ST_EMPTY` to `ST_HELD`): an edge produces no bit, and its interval is kept.
- *replace* (`ST_HELD` to `ST_HELD`): an edge produces no bit, and its interval overwrites the held one.
- *consume* (`ST_HELD` to `ST_EMPTY`): an edge produces a bit, and the history is dropped.

An edge that produces a bit while in `ST_EMPTY` leaves the state unchanged.

Top module: `biphase_interval_decoder`

## Requirements
- R1: After synchronous active-high reset, the strobes `bit_valid` and `abort_pulse` are low, no interval is held, and the interval counter is zero.
- R2: `line_in` passes through a synchronizer of `SYNC_STAGES` flops. Both rising and falling edges are detected. The interval of an edge is the exact number of clock cycles since the previous edge. The counter saturates at its all-ones value and never wraps.
- R3: The tolerance window is strict: a value `x` is in the window when `LO < x < HI`, where `LO = floor(3P/4)` and `HI = floor(5P/4)`. For `P = 40`, this means 31 to 49 inclusive.
- R4: On an edge, when an interval is held and the held interval plus the current interval lies in the window, a one is emitted. This rule has priority over R5.
- R5: Otherwise, when the current interval alone lies in the window, a zero is emitted.
- R6: Otherwise, a one is emitted when all of the following hold: an interval is held, the line is low after the edge, twice the current interval lies in the window, and the held interval exceeds `HI`. If the line is high after the edge, this rule does not apply.
- R7: An edge whose interval exceeds `HI` and that produces no bit raises `abort_pulse`.
- R8: After any emitted bit the history is empty. An edge that emits no bit, including an abort, replaces the history with its own interval, so only the most recent unmatched interval is ever paired.
- R9: `bit_valid` and `abort_pulse` are registered one-cycle strobes and are never high together. `bit_value` is meaningful while `bit_valid` is high: 1 means a one, 0 means a zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Demodulated bi-phase data line (asynchronous) |
| bit_valid | output | 1 | One-cycle strobe: a bit was decoded |
| bit_value | output | 1 | Decoded bit, valid with `bit_valid` |
| abort_pulse | output | 1 | One-cycle strobe: over-long gap, framing must go idle |

## Verification
The in-line assertions check several properties on every cycle:

- The two strobes never coincide.
- Every strobe follows an edge.
- An abort only follows an interval above `HI`, and a zero only follows an in-window interval.
- The history is empty whenever a bit is reported.
- The counter restarts at one after an edge and holds once saturated.

Only the bench's edge scenarios can show that the rule priority is right and that the boundary counts 30, 31, 49 and 50 fall on the correct side. They also show the effect of the line-level gate on the long-gap rule, the replacement of the held interval, and saturation across a gap far longer than the counter's range.

// File: rtl/bip_pkg.sv
package bip_pkg;

    // Outcome of classifying one edge interval
    typedef enum logic [1:0] {
        DEC_NONE  = 2'd0,
        DEC_ZERO  = 2'd1,
        DEC_ONE   = 2'd2,
        DEC_ABORT = 2'd3
    } bip_dec_e;

    // History state: whether one earlier interval is held
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } bip_state_e;

endpackage

// File: rtl/bip_sync_edge.sv
module bip_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic level,
    output logic edge_hit
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= line_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[STAGES-1];
    end

    assign level    = chain_q[STAGES-1];
    assign edge_hit = chain_q[STAGES-1] ^ last_q;

    // R2: an edge is always followed by the new level being remembered
    a_r2_edge_tracks: assert property (@(posedge clk) disable iff (rst)
        edge_hit |=> (last_q == $past(level)));

endmodule

// File: rtl/bip_interval_ctr.sv
module bip_interval_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          edge_hit,
    output logic [CW-1:0] interval
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (edge_hit)       cnt_q <= CW'(1);
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CW'(1);
    end

    // Cycles since the previous edge, counting the edge cycle itself
    assign interval = cnt_q;

    // R2: restart at one after every edge
    a_r2_restart: assert property (@(posedge clk) disable iff (rst)
        edge_hit |=> (cnt_q == CW'(1)));

    // R2: saturation, never wrap
    a_r2_saturate: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !edge_hit) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/bip_classify.sv
module bip_classify
    import bip_pkg::*;
#(
    parameter int CW     = 16,
    parameter int LO_CYC = 18750,
    parameter int HI_CYC = 31250
) (
    input  logic [CW-1:0] interval,
    input  logic [CW-1:0] prev,
    input  logic          prev_valid,
    input  logic          line_low,
    output bip_dec_e      decision
);
    localparam logic [CW:0] LO_W = (CW+1)'(LO_CYC);
    localparam logic [CW:0] HI_W = (CW+1)'(HI_CYC);

    logic [CW:0] ivl_w, prev_w, sum_w, dbl_w;
    logic        pair_ok, single_ok, late_ok, long_gap;

    function automatic logic in_win(input logic [CW:0] x);
        return (x > LO_W) && (x < HI_W);
    endfunction

    always_comb begin
        ivl_w     = {1'b0, interval};
        prev_w    = {1'b0, prev};
        sum_w     = prev_w + ivl_w;
        dbl_w     = {interval, 1'b0};
        pair_ok   = prev_valid && in_win(sum_w);
        single_ok = in_win(ivl_w);
        late_ok   = prev_valid && line_low && in_win(dbl_w) && (prev_w > HI_W);
        long_gap  = ivl_w > HI_W;

        if (pair_ok)        decision = DEC_ONE;
        else if (single_ok) decision = DEC_ZERO;
        else if (late_ok)   decision = DEC_ONE;
        else if (long_gap)  decision = DEC_ABORT;
        else                decision = DEC_NONE;
    end

endmodule

// File: rtl/biphase_interval_decoder.sv
module biphase_interval_decoder
    import bip_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int BIT_HZ      = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic bit_valid,
    output logic bit_value,
    output logic abort_pulse
);
    localparam int PERIOD = CLK_HZ / BIT_HZ;
    localparam int LO_CYC = (PERIOD * 3) / 4;
    localparam int HI_CYC = (PERIOD * 5) / 4;
    localparam int CW     = $clog2(HI_CYC + 1) + 1;
    localparam logic [CW:0] LO_W = (CW+1)'(LO_CYC);
    localparam logic [CW:0] HI_W = (CW+1)'(HI_CYC);

    logic          level, edge_hit;
    logic [CW-1:0] interval;
    logic [CW-1:0] hist_q, hist_d;
    bip_state_e    state_q, state_d;
    bip_dec_e      decision;
    logic          emits_bit;

    bip_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .line_in  (line_in),
        .level    (level),
        .edge_hit (edge_hit)
    );

    bip_interval_ctr #(.CW(CW)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .edge_hit (edge_hit),
        .interval (interval)
    );

    bip_classify #(.CW(CW), .LO_CYC(LO_CYC), .HI_CYC(HI_CYC)) u_cls (
        .interval   (interval),
        .prev       (hist_q),
        .prev_valid (state_q == ST_HELD),
        .line_low   (!level),
        .decision   (decision)
    );

    assign emits_bit = (decision == DEC_ONE) || (decision == DEC_ZERO);

    // Next state: stash / replace / consume
    always_comb begin
        state_d = state_q;
        hist_d  = hist_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (edge_hit && !emits_bit) begin
                    state_d = ST_HELD;      // stash
                    hist_d  = interval;
                end
            end
            ST_HELD: begin
                if (edge_hit) begin
                    if (emits_bit) begin
                        state_d = ST_EMPTY; // consume
                        hist_d  = '0;
                    end else begin
                        hist_d  = interval; // replace
                    end
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
            hist_q  <= '0;
        end else begin
            state_q <= state_d;
            hist_q  <= hist_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_valid   <= 1'b0;
            bit_value   <= 1'b0;
            abort_pulse <= 1'b0;
        end else begin
            bit_valid   <= edge_hit && emits_bit;
            abort_pulse <= edge_hit && (decision == DEC_ABORT);
            if (edge_hit && emits_bit) bit_value <= (decision == DEC_ONE);
        end
    end

    // R9: strobes never coincide
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(bit_valid && abort_pulse));

    // R9: every strobe is caused by an edge one cycle earlier
    a_r9_after_edge: assert property (@(posedge clk) disable iff (rst)
        (bit_valid || abort_pulse) |-> $past(edge_hit));

    // R7: abort only after an over-long interval
    a_r7_abort_long: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> ({1'b0, $past(interval)} > HI_W));

    // R5: a zero only after an in-window interval
    a_r5_zero_window: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && !bit_value) |->
            (({1'b0, $past(interval)} > LO_W) && ({1'b0, $past(interval)} < HI_W)));

    // R8: history is empty whenever a bit is reported
    a_r8_hist_clear: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> (state_q == ST_EMPTY));

endmodule

// File: tb/biphase_interval_decoder_test.sv
`timescale 1ns/1ps
module biphase_interval_decoder_test;
    localparam int K_NONE = 0, K_ZERO = 1, K_ONE = 2, K_ABORT = 3;
    localparam int MAX_CYC = 200_000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_in = 1'b0;
    logic bit_valid, bit_value, abort_pulse;

    int    checks = 0;
    int    errors = 0;
    int    exp_q[$];
    string tag_q[$];
    int    strobes_seen = 0;
    int    seen_snap = 0;
    int    last_kind = K_ABORT;
    string last_tag = "";
    bit    done = 1'b0;

    always #10 clk = ~clk;

    biphase_interval_decoder #(.CLK_HZ(80_000), .BIT_HZ(2000), .SYNC_STAGES(2)) uut (
        .clk         (clk),
        .rst         (rst),
        .line_in     (line_in),
        .bit_valid   (bit_valid),
        .bit_value   (bit_value),
        .abort_pulse (abort_pulse)
    );

    function automatic string kname(input int k);
        case (k)
            K_ZERO:  return "zero";
            K_ONE:   return "one";
            K_ABORT: return "abort";
            default: return "none";
        endcase
    endfunction

    // Monitor: pop and compare each strobe
    always @(negedge clk) begin
        if (!rst && (bit_valid || abort_pulse)) begin
            int got;
            strobes_seen++;
            checks++;
            if (bit_valid && abort_pulse) begin
                errors++;
                $display("FAIL R9: both strobes high, actual=both expected=one strobe");
            end
            got = abort_pulse ? K_ABORT : (bit_value ? K_ONE : K_ZERO);
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9: unexpected strobe, actual=%s expected=nothing", kname(got));
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (got != e) begin
                    errors++;
                    $display("FAIL %s: actual=%s expected=%s", t, kname(got), kname(e));
                end
            end
        end
    end

    // Driver: wait n cycles, toggle the line, push the expected outcome
    task automatic step(input int n, input int kind, input string tag);
        repeat (n) @(negedge clk);
        if (last_kind == K_NONE) begin
            checks++;
            if (strobes_seen != seen_snap) begin
                errors++;
                $display("FAIL %s: strobes after ignored edge actual=%0d expected=0",
                         last_tag, strobes_seen - seen_snap);
            end
        end
        seen_snap = strobes_seen;
        last_kind = kind;
        last_tag  = tag;
        if (kind != K_NONE) begin
            exp_q.push_back(kind);
            tag_q.push_back(tag);
        end
        line_in = ~line_in;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (bit_valid !== 1'b0 || abort_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R1: reset strobes actual=%b%b expected=00", bit_valid, abort_pulse);
        end
        // P=40: window 31..49, HI=50
        step(100, K_ABORT, "R7");   // long first gap
        step(20,  K_ONE,   "R6");   // half after long gap, line low
        step(40,  K_ZERO,  "R5");
        step(20,  K_NONE,  "R8");   // held
        step(20,  K_ONE,   "R4");   // pair 40
        step(31,  K_ZERO,  "R3");   // lower bound inside
        step(30,  K_NONE,  "R3");   // lower bound outside, held
        step(19,  K_ONE,   "R3");   // pair 49 inside
        step(49,  K_ZERO,  "R3");   // upper bound inside
        step(50,  K_NONE,  "R3");   // upper bound outside, not long
        step(4,   K_NONE,  "R8");   // replaces held 50
        step(36,  K_ONE,   "R4");   // pair 40 beats single 36
        step(70,  K_ABORT, "R7");
        step(40,  K_ZERO,  "R5");
        step(70,  K_ABORT, "R7");
        step(20,  K_ONE,   "R6");
        step(40,  K_ZERO,  "R5");
        step(70,  K_ABORT, "R7");   // line goes low
        step(20,  K_NONE,  "R6");   // line high after edge: no bit
        step(20,  K_ONE,   "R4");   // pair 20+20
        step(1030, K_ABORT, "R2");  // far beyond counter range: saturates
        step(20,  K_ONE,   "R2");   // held value still above HI
        repeat (20) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9: missing strobes actual=%0d pending expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9: watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule